// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Scheduler

This block holds a small buffer of pending DRAM requests. Each request carries a thread number, a bank and a row. In every scheduling slot the block picks one request. It knows which row is open in each bank. A request whose row is already open costs roughly half the access time of one that must close a row and open another. For that reason the normal order puts open-row requests first and then takes requests by arrival order. A separate slowdown monitor drives two inputs: a fairness-mode flag and the number of the thread that is currently slowed the most. While the fairness mode is on, requests from that thread go ahead of every other request. Open-row status and arrival order then decide among the rest.

A grant leaves the block as a registered record one cycle after the slot in which it was chosen. The record holds the entry index, thread, bank and row, and whether the request was an open-row hit. The granted entry leaves the buffer at once, and the granted row becomes the open row of its bank. Command timing, refresh and data movement sit downstream and are not part of this block.

Top module: `dram_fair_sched`

## Requirements
- R1: After reset, gnt_valid and full are 0 and every bank is treated as having no open row, so the first grant to any bank reports gnt_hit = 0.
- R2: A request offered with req_valid = 1 while full = 0 is stored in the lowest-numbered free entry, and at most one is stored per cycle. full rises once all DEPTH entries are occupied. A request offered while full = 1 is dropped and is never granted.
- R3: When slot_go = 1 and at least one entry is occupied, one entry is chosen. Its index, thread, bank, row and hit flag appear on the gnt_* outputs with gnt_valid = 1 in the next cycle. That entry is freed and is never granted twice. When slot_go = 0 or the buffer is empty, gnt_valid is 0 in the next cycle.
- R4: When fair_mode = 0, a request whose row equals the open row of its bank is chosen over any request that is not a hit.
- R5: Among candidates of equal rank, the request that arrived earliest is chosen, whatever its entry index.
- R6: When fair_mode = 1 and some stored request has thread slow_tid, the grant goes to a request of that thread. Among those requests, hits come first and then arrival order.
- R7: When fair_mode = 1 and no stored request has thread slow_tid, selection is the same as with fair_mode = 0: hits first, then arrival order.
- R8: After a grant, the granted row is the open row of the granted bank. gnt_hit is 1 exactly when the request's row matched its bank's open row in the slot in which it was chosen.
- R9: A request can be stored in the same cycle in which another entry is granted, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request offered this cycle |
| req_tid | input | TID_W | Thread of the new request |
| req_bank | input | BANK_W | Bank of the new request |
| req_row | input | ROW_W | Row of the new request |
| full | output | 1 | Every buffer entry is occupied |
| slot_go | input | 1 | Scheduling slot: choose one request this cycle |
| fair_mode | input | 1 | 1 selects the fairness priority order |
| slow_tid | input | TID_W | Thread with the largest slowdown |
| gnt_valid | output | 1 | Registered grant is present |
| gnt_idx | output | IDX_W | Buffer entry that was granted |
| gnt_tid | output | TID_W | Thread of the granted request |
| gnt_bank | output | BANK_W | Bank of the granted request |
| gnt_row | output | ROW_W | Row of the granted request |
| gnt_hit | output | 1 | Granted request hit the open row |

## Verification
Suppose the arrival-order matrix is corrupted. Two requests of equal rank then leave in the wrong order, and that shows at the grant port one cycle after the slot that held both of them. A wrong open-row entry shows either as a wrong gnt_hit or as a miss granted ahead of a waiting hit in the next slot that involves that bank. A stuck or lost occupancy bit shows as a duplicate grant, a missing grant or a wrong full flag. The bench checks this at the first slot that drains the affected entry, because a reference model tracks the expected grant for every cycle.

// File: rtl/fsched_pkg.sv
`timescale 1ns/1ps
package fsched_pkg;

  // Rank of a candidate: bit 1 = favoured thread tier, bit 0 = open-row hit
  typedef logic [1:0] rank_t;

  function automatic rank_t make_rank(input logic fair_on,
                                      input logic is_slow,
                                      input logic is_hit);
    make_rank = {fair_on & is_slow, is_hit};
  endfunction

endpackage

// File: rtl/fsched_buffer.sv
`timescale 1ns/1ps
module fsched_buffer #(
  parameter int DEPTH  = 16,
  parameter int TID_W  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [TID_W-1:0]              wr_tid,
  input  logic [BANK_W-1:0]             wr_bank,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic                          rm_en,
  input  logic [IDX_W-1:0]              rm_idx,
  output logic [DEPTH-1:0]              valid_q,
  output logic [DEPTH-1:0][TID_W-1:0]   tid_q,
  output logic [DEPTH-1:0][BANK_W-1:0]  bank_q,
  output logic [DEPTH-1:0][ROW_W-1:0]   row_q,
  output logic [DEPTH-1:0][DEPTH-1:0]   older_q,
  output logic                          full
);

  logic [IDX_W-1:0]            free_idx;
  logic                        accept;
  logic [DEPTH-1:0]            rm_mask;
  logic [DEPTH-1:0]            valid_d;
  logic [DEPTH-1:0][DEPTH-1:0] older_d;

  assign full   = &valid_q;
  assign accept = wr_en & ~full;

  // Lowest free entry
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rm_mask = '0;
    if (rm_en) rm_mask[rm_idx] = 1'b1;
  end

  // Next state: occupancy and arrival-order matrix
  always_comb begin
    valid_d = valid_q & ~rm_mask;
    if (accept) valid_d[free_idx] = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      older_d[k] = older_q[k] & ~rm_mask;
    end
    if (accept) older_d[free_idx] = valid_q & ~rm_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      older_q <= '0;
    end else begin
      valid_q <= valid_d;
      older_q <= older_d;
    end
  end

  // Payload storage with per-entry write enables
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = accept && (free_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        tid_q[g]  <= wr_tid;
        bank_q[g] <= wr_bank;
        row_q[g]  <= wr_row;
      end
    end
  end

endmodule

// File: rtl/fsched_openrow.sv
`timescale 1ns/1ps
module fsched_openrow #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_en,
  input  logic [BANK_W-1:0]            upd_bank,
  input  logic [ROW_W-1:0]             upd_row,
  output logic [NBANK-1:0]             open_v,
  output logic [NBANK-1:0][ROW_W-1:0]  open_row
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    logic v_d;
    assign bank_we = upd_en && (upd_bank == BANK_W'(b));
    assign v_d     = open_v[b] | bank_we;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_v[b]   <= 1'b0;
        open_row[b] <= '0;
      end else begin
        open_v[b] <= v_d;
        if (bank_we) open_row[b] <= upd_row;
      end
    end
  end

endmodule

// File: rtl/fsched_pick.sv
`timescale 1ns/1ps
module fsched_pick
  import fsched_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TID_W  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [DEPTH-1:0]              valid,
  input  logic [DEPTH-1:0][TID_W-1:0]   tid,
  input  logic [DEPTH-1:0][BANK_W-1:0]  bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   row,
  input  logic [DEPTH-1:0][DEPTH-1:0]   older,
  input  logic [NBANK-1:0]              open_v,
  input  logic [NBANK-1:0][ROW_W-1:0]   open_row,
  input  logic                          fair_mode,
  input  logic [TID_W-1:0]              slow_tid,
  output logic [DEPTH-1:0]              hit_vec,
  output logic                          any_valid,
  output logic [IDX_W-1:0]              win_idx,
  output logic                          win_hit
);

  rank_t            rank [DEPTH];
  logic [DEPTH-1:0] win_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rank
    assign hit_vec[i] = open_v[bank[i]] && (open_row[bank[i]] == row[i]);
    assign rank[i]    = make_rank(fair_mode, tid[i] == slow_tid, hit_vec[i]);
  end

  // Entry i wins if it beats every other occupied entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    logic [DEPTH-1:0] beats;
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      if (i == j) begin : g_self
        assign beats[j] = 1'b1;
      end else begin : g_other
        assign beats[j] = !valid[j] || (rank[i] > rank[j]) ||
                          ((rank[i] == rank[j]) && older[j][i]);
      end
    end
    assign win_vec[i] = valid[i] && (&beats);
  end

  assign any_valid = |valid;

  // Encode, lowest index taken if more than one were ever set
  always_comb begin
    win_idx = '0;
    win_hit = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (win_vec[i]) begin
        win_idx = IDX_W'(i);
        win_hit = hit_vec[i];
      end
    end
  end

endmodule

// File: rtl/dram_fair_sched.sv
`timescale 1ns/1ps
module dram_fair_sched #(
  parameter int DEPTH  = 16,
  parameter int TID_W  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              full,
  input  logic              slot_go,
  input  logic              fair_mode,
  input  logic [TID_W-1:0]  slow_tid,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic [TID_W-1:0]  gnt_tid,
  output logic [BANK_W-1:0] gnt_bank,
  output logic [ROW_W-1:0]  gnt_row,
  output logic              gnt_hit
);

  logic [DEPTH-1:0]              valid_vec;
  logic [DEPTH-1:0][TID_W-1:0]   tid_vec;
  logic [DEPTH-1:0][BANK_W-1:0]  bank_vec;
  logic [DEPTH-1:0][ROW_W-1:0]   row_vec;
  logic [DEPTH-1:0][DEPTH-1:0]   older_mat;
  logic [NBANK-1:0]              open_v;
  logic [NBANK-1:0][ROW_W-1:0]   open_row;
  logic [DEPTH-1:0]              hit_vec;
  logic                          any_valid;
  logic [IDX_W-1:0]              win_idx;
  logic                          win_hit;
  logic                          issue;

  assign issue = slot_go & any_valid;

  fsched_buffer #(
    .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_valid),
    .wr_tid  (req_tid),
    .wr_bank (req_bank),
    .wr_row  (req_row),
    .rm_en   (issue),
    .rm_idx  (win_idx),
    .valid_q (valid_vec),
    .tid_q   (tid_vec),
    .bank_q  (bank_vec),
    .row_q   (row_vec),
    .older_q (older_mat),
    .full    (full)
  );

  fsched_openrow #(
    .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_open (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (issue),
    .upd_bank (bank_vec[win_idx]),
    .upd_row  (row_vec[win_idx]),
    .open_v   (open_v),
    .open_row (open_row)
  );

  fsched_pick #(
    .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_pick (
    .valid     (valid_vec),
    .tid       (tid_vec),
    .bank      (bank_vec),
    .row       (row_vec),
    .older     (older_mat),
    .open_v    (open_v),
    .open_row  (open_row),
    .fair_mode (fair_mode),
    .slow_tid  (slow_tid),
    .hit_vec   (hit_vec),
    .any_valid (any_valid),
    .win_idx   (win_idx),
    .win_hit   (win_hit)
  );

  // Grant register: next-state values, then the flops
  logic              gv_d;
  logic [IDX_W-1:0]  gi_d;
  logic [TID_W-1:0]  gt_d;
  logic [BANK_W-1:0] gb_d;
  logic [ROW_W-1:0]  gr_d;
  logic              gh_d;

  always_comb begin
    gv_d = issue;
    gi_d = win_idx;
    gt_d = tid_vec[win_idx];
    gb_d = bank_vec[win_idx];
    gr_d = row_vec[win_idx];
    gh_d = win_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      gnt_tid   <= '0;
      gnt_bank  <= '0;
      gnt_row   <= '0;
      gnt_hit   <= 1'b0;
    end else begin
      gnt_valid <= gv_d;
      if (issue) begin
        gnt_idx  <= gi_d;
        gnt_tid  <= gt_d;
        gnt_bank <= gb_d;
        gnt_row  <= gr_d;
        gnt_hit  <= gh_d;
      end
    end
  end

endmodule

// File: rtl/dram_fair_sched_chk.sv
`timescale 1ns/1ps
module dram_fair_sched_chk #(
  parameter int DEPTH  = 16,
  parameter int TID_W  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NBANK = 1 << BANK_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         full,
  input logic                         slot_go,
  input logic                         fair_mode,
  input logic [TID_W-1:0]             slow_tid,
  input logic [DEPTH-1:0]             valid_vec,
  input logic [DEPTH-1:0][TID_W-1:0]  tid_vec,
  input logic [DEPTH-1:0]             hit_vec,
  input logic [NBANK-1:0]             open_v,
  input logic [NBANK-1:0][ROW_W-1:0]  open_row,
  input logic                         gnt_valid,
  input logic [IDX_W-1:0]             gnt_idx,
  input logic [TID_W-1:0]             gnt_tid,
  input logic [BANK_W-1:0]            gnt_bank,
  input logic [ROW_W-1:0]             gnt_row,
  input logic                         gnt_hit
);

  logic slow_present;
  logic any_hit;
  logic [DEPTH-1:0] valid_prev;

  always_comb begin
    slow_present = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_vec[i] && tid_vec[i] == slow_tid) slow_present = 1'b1;
    end
    any_hit = |(valid_vec & hit_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_prev <= '0;
    else        valid_prev <= valid_vec;
  end

  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_go && |valid_vec) |=> !gnt_valid); // R3

  AST_GNT_WAS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> valid_prev[gnt_idx]); // R3

  AST_GNT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> !valid_vec[gnt_idx]); // R3

  AST_FULL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(req_valid)); // R2

  AST_OPEN_ROW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (open_v[gnt_bank] && open_row[gnt_bank] == gnt_row)); // R8

  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && !fair_mode && any_hit) |=> gnt_hit); // R4

  AST_SLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && fair_mode && slow_present) |=> (gnt_tid == $past(slow_tid))); // R6

endmodule

bind dram_fair_sched dram_fair_sched_chk #(
  .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .full      (full),
  .slot_go   (slot_go),
  .fair_mode (fair_mode),
  .slow_tid  (slow_tid),
  .valid_vec (valid_vec),
  .tid_vec   (tid_vec),
  .hit_vec   (hit_vec),
  .open_v    (open_v),
  .open_row  (open_row),
  .gnt_valid (gnt_valid),
  .gnt_idx   (gnt_idx),
  .gnt_tid   (gnt_tid),
  .gnt_bank  (gnt_bank),
  .gnt_row   (gnt_row),
  .gnt_hit   (gnt_hit)
);

// File: tb/dram_fair_sched_bench.sv
`timescale 1ns/1ps
module dram_fair_sched_bench;

  localparam int DEPTH  = 16;
  localparam int TID_W  = 2;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 8;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int NBANK  = 1 << BANK_W;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [TID_W-1:0]  req_tid;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic              full;
  logic              slot_go;
  logic              fair_mode;
  logic [TID_W-1:0]  slow_tid;
  logic              gnt_valid;
  logic [IDX_W-1:0]  gnt_idx;
  logic [TID_W-1:0]  gnt_tid;
  logic [BANK_W-1:0] gnt_bank;
  logic [ROW_W-1:0]  gnt_row;
  logic              gnt_hit;

  dram_fair_sched #(
    .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_dram_fair_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_bank(req_bank), .req_row(req_row), .full(full), .slot_go(slot_go),
    .fair_mode(fair_mode), .slow_tid(slow_tid), .gnt_valid(gnt_valid),
    .gnt_idx(gnt_idx), .gnt_tid(gnt_tid), .gnt_bank(gnt_bank),
    .gnt_row(gnt_row), .gnt_hit(gnt_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  string cur_tag = "R1";

  typedef struct {
    bit    v;
    int    idx;
    int    tid;
    int    bank;
    int    row;
    bit    hit;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state
  bit m_v   [DEPTH];
  int m_tid [DEPTH];
  int m_bank[DEPTH];
  int m_row [DEPTH];
  int m_seq [DEPTH];
  bit o_v   [NBANK];
  int o_row [NBANK];
  int seq_ctr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int m_rank(int i, bit fm, int st);
    int r;
    r = 0;
    if (fm && m_tid[i] == st) r += 2;
    if (o_v[m_bank[i]] && o_row[m_bank[i]] == m_row[i]) r += 1;
    return r;
  endfunction

  // Driver: one cycle of stimulus, expected grant pushed for the next cycle
  task automatic step(input bit rv, input int t, input int b, input int r,
                      input bit go, input bit fm, input int st);
    exp_t e;
    int   best;
    int   cnt;
    int   fr;
    @(negedge clk);
    req_valid = rv;
    req_tid   = TID_W'(t);
    req_bank  = BANK_W'(b);
    req_row   = ROW_W'(r);
    slot_go   = go;
    fair_mode = fm;
    slow_tid  = TID_W'(st);
    e.v = 0; e.idx = 0; e.tid = 0; e.bank = 0; e.row = 0; e.hit = 0;
    e.tag = cur_tag;
    cnt = 0;
    fr  = -1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m_v[i]) cnt++;
      else fr = i;
    end
    best = -1;
    if (go) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (m_v[i]) begin
          if (best < 0) best = i;
          else if (m_rank(i, fm, st) > m_rank(best, fm, st)) best = i;
          else if (m_rank(i, fm, st) == m_rank(best, fm, st) &&
                   m_seq[i] < m_seq[best]) best = i;
        end
      end
    end
    if (best >= 0) begin
      e.v    = 1;
      e.idx  = best;
      e.tid  = m_tid[best];
      e.bank = m_bank[best];
      e.row  = m_row[best];
      e.hit  = o_v[m_bank[best]] && o_row[m_bank[best]] == m_row[best];
      m_v[best] = 0;
      o_v[m_bank[best]]   = 1;
      o_row[m_bank[best]] = m_row[best];
    end
    if (rv && cnt < DEPTH) begin
      m_v[fr]    = 1;
      m_tid[fr]  = t;
      m_bank[fr] = b;
      m_row[fr]  = r;
      m_seq[fr]  = seq_ctr;
      seq_ctr++;
    end
    exp_q.push_back(e);
  endtask

  task automatic put(input int t, input int b, input int r);
    step(1, t, b, r, 0, 0, 0);
  endtask

  task automatic drain(input int n, input bit fm, input int st);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 1, fm, st);
  endtask

  // Monitor: compares each cycle's grant against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(gnt_valid == e.v, e.tag, "gnt_valid", int'(gnt_valid), int'(e.v));
        if (e.v && gnt_valid) begin
          chk(int'(gnt_idx) == e.idx, e.tag, "gnt_idx", int'(gnt_idx), e.idx);
          chk(int'(gnt_tid) == e.tid, e.tag, "gnt_tid", int'(gnt_tid), e.tid);
          chk(int'(gnt_bank) == e.bank, e.tag, "gnt_bank", int'(gnt_bank), e.bank);
          chk(int'(gnt_row) == e.row, e.tag, "gnt_row", int'(gnt_row), e.row);
          chk(gnt_hit == e.hit, e.tag, "gnt_hit", int'(gnt_hit), int'(e.hit));
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    for (int b = 0; b < NBANK; b++) begin o_v[b] = 0; o_row[b] = 0; end
    rst_n = 0; req_valid = 0; req_tid = '0; req_bank = '0; req_row = '0;
    slot_go = 0; fair_mode = 0; slow_tid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    chk(gnt_valid == 1'b0, "R1", "reset gnt_valid", int'(gnt_valid), 0);
    chk(full == 1'b0, "R1", "reset full", int'(full), 0);

    // R1 / R8: closed bank misses, then the same row hits
    cur_tag = "R8";
    put(0, 0, 5);
    drain(1, 0, 0);
    put(1, 0, 5);
    drain(1, 0, 0);

    // R4: a hit overtakes older misses
    cur_tag = "R4";
    put(0, 1, 3); drain(1, 0, 0);
    put(0, 1, 7); put(1, 2, 1); put(2, 1, 3);
    drain(3, 0, 0);

    // R5: arrival order, not index order
    cur_tag = "R5";
    for (int k = 0; k < 6; k++) put(k % 4, 3 + (k % 3), 20 + k);
    drain(2, 0, 0);
    put(3, 6, 40); put(2, 7, 41);
    drain(6, 0, 0);

    // R6: favoured thread first in fairness mode
    cur_tag = "R6";
    put(0, 1, 3); drain(1, 0, 0);
    put(2, 4, 90); put(0, 1, 3); put(1, 1, 3); put(2, 5, 91); put(2, 1, 3);
    drain(5, 1, 2);

    // R7: fairness mode with the favoured thread absent
    cur_tag = "R7";
    put(0, 2, 60); put(1, 1, 3); put(0, 2, 61); put(1, 1, 3);
    drain(4, 1, 3);

    // R2 / R3: fill, overflow attempt, drain past empty
    cur_tag = "R2";
    for (int k = 0; k < DEPTH; k++) put(k % 4, k % NBANK, 100 + k);
    put(3, 7, 250);
    @(posedge clk); #2;
    chk(full == 1'b1, "R2", "full after fill", int'(full), 1);
    cur_tag = "R3";
    drain(DEPTH + 1, 0, 0);
    @(posedge clk); #2;
    chk(full == 1'b0, "R2", "full after drain", int'(full), 0);

    // R9: store and grant in the same cycle
    cur_tag = "R9";
    put(1, 0, 9);
    step(1, 2, 0, 9, 1, 0, 0);
    step(1, 3, 3, 2, 1, 0, 0);
    drain(2, 0, 0);

    // Mixed traffic in both modes
    cur_tag = "R5";
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 9) < 6, $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 1) == 1,
           ((k / 50) % 2) == 1, $urandom_range(0, 3));
    end
    cur_tag = "R3";
    drain(DEPTH + 2, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk); #3;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule